// File: doc/BRIEF.md
# Three-Operand Residue Adder with CRT Reconstruction

The block adds or subtracts three 10-bit unsigned operands without any carry chain across the full result width. Each operand is reduced to its remainders modulo 10, 9 and 7. Three independent channels each combine one remainder per operand. A subtracted operand enters its channel as the additive complement of its remainder. The binary result is then rebuilt from the three channel residues with the Chinese Remainder Theorem. Because the moduli are pairwise coprime, the rebuilt value is unique in the range 0 to 629. A true result outside that range wraps modulo 630.

Operands and their add/subtract flags arrive on a valid/ready input. The three residues and the rebuilt value leave on a valid/ready output. A two-stage registered pipeline sits between the two. Stage one holds the residues and stage two holds the rebuilt value. Back-pressure on the output stalls both stages without losing data.

Top module: `rnsAdder`

## Requirements
- R1: With no subtract flag set, output residue channel 0, 1 and 2 equals (opA + opB + opC) mod 10, mod 9 and mod 7 respectively.
- R2: A set subtract flag (subA, subB, subC for opA, opB, opC) makes its operand contribute (m − (X mod m)) mod m to the channel of modulus m. A residue of zero therefore contributes zero.
- R3: outValue equals the signed sum (each operand negated when its flag is set) taken modulo 630 into the range 0 to 629. A true sum of 835 gives 205, and a true sum of −5 gives 625.
- R4: While outValid is high, outValue is below 630 and outValue mod 10, mod 9 and mod 7 equal resCh0, resCh1 and resCh2.
- R5: When an input is accepted at clock edge k and the pipeline is empty, outValid is low after edge k and high after edge k+1.
- R6: While outValid is high and outReady is low, outValid and every output field hold their values across the next edge. With both stages full and stalled, inReady is low. Every accepted input appears exactly once and in order.
- R7: Whenever outValid is low, inReady is high.
- R8: During reset, outValid is low and inReady is high.
- R9: The channel module is parameterised by its modulus. With modulus 12, adding 10 and 7 and subtracting 3 gives 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operand set offered |
| inReady | output | 1 | Operand set can be taken this cycle |
| opA | input | 10 | First operand |
| opB | input | 10 | Second operand |
| opC | input | 10 | Third operand |
| subA | input | 1 | Subtract opA instead of adding it |
| subB | input | 1 | Subtract opB instead of adding it |
| subC | input | 1 | Subtract opC instead of adding it |
| outValid | output | 1 | Result available |
| outReady | input | 1 | Consumer takes the result this cycle |
| resCh0 | output | 4 | Result residue modulo 10 |
| resCh1 | output | 4 | Result residue modulo 9 |
| resCh2 | output | 4 | Result residue modulo 7 |
| outValue | output | 10 | Reconstructed result, 0 to 629 |

## Verification
The assertions assume the consumer follows the handshake. They also assume inValid is held low before and during reset, so the two-edge history behind the latency property never reaches undefined input values. The bench drives inputs only on falling edges and keeps inValid low throughout reset. It sweeps every value of opA with all eight subtract-flag patterns, pairs each with derived opB and opC values, and alternates free flow with output stalls. This keeps the stalled-output properties exercised without ever breaking the handshake.

// File: rtl/rnsPkg.sv
package rnsPkg;
  localparam int NCH  = 3;
  localparam int NOPS = 3;
  localparam int OPW  = 10;
  localparam int MODS [NCH] = '{10, 9, 7};

  function automatic int prodAll();
    int p = 1;
    for (int i = 0; i < NCH; i++) p = p * MODS[i];
    return p;
  endfunction

  function automatic int maxMod();
    int mx = 0;
    for (int i = 0; i < NCH; i++) if (MODS[i] > mx) mx = MODS[i];
    return mx;
  endfunction

  localparam int MTOT = prodAll();
  localparam int RESW = $clog2(maxMod());
  localparam int VALW = $clog2(MTOT);

  // weight of channel i: (MTOT/m_i) times its inverse modulo m_i
  function automatic int crtWeight(int i);
    int big = MTOT / MODS[i];
    int inv = 0;
    for (int k = 1; k < MODS[i]; k++)
      if (((big * k) % MODS[i]) == 1) inv = k;
    return big * inv;
  endfunction

  typedef struct packed {
    logic load1;
    logic load2;
  } ctrlStrobes_t;
endpackage

// File: rtl/rnsChannel.sv
module rnsChannel #(
  parameter int MOD  = 10,
  parameter int OPW  = 10,
  parameter int NOPS = 3,
  parameter int RESW = $clog2(MOD)
) (
  input  logic [NOPS-1:0][OPW-1:0] ops,
  input  logic [NOPS-1:0]          subs,
  output logic [RESW-1:0]          residue
);
  int partVal [NOPS];
  int accSum;

  genvar g;
  generate
    for (g = 0; g < NOPS; g++) begin : gReduce
      always_comb begin
        partVal[g] = int'(ops[g]) % MOD;
        if (subs[g] && partVal[g] != 0) partVal[g] = MOD - partVal[g];
      end
    end
  endgenerate

  always_comb begin
    accSum = 0;
    for (int i = 0; i < NOPS; i++) begin
      accSum = accSum + partVal[i];
      if (accSum >= MOD) accSum = accSum - MOD;
    end
    residue = RESW'(accSum);
  end
endmodule

// File: rtl/rnsCtrl.sv
module rnsCtrl
  import rnsPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         outReady,
  output logic         inReady,
  output logic         outValid,
  output ctrlStrobes_t strobes
);
  logic s1Valid, s2Valid;

  always_comb begin
    strobes.load2 = s1Valid && (!s2Valid || outReady);
    inReady       = !s1Valid || strobes.load2;
    strobes.load1 = inValid && inReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s2Valid <= 1'b0;
    end else begin
      if (strobes.load1)      s1Valid <= 1'b1;
      else if (strobes.load2) s1Valid <= 1'b0;
      if (strobes.load2)      s2Valid <= 1'b1;
      else if (outReady)      s2Valid <= 1'b0;
    end
  end

  assign outValid = s2Valid;
endmodule

// File: rtl/rnsDatapath.sv
module rnsDatapath
  import rnsPkg::*;
(
  input  logic                     clk,
  input  ctrlStrobes_t             strobes,
  input  logic [NOPS-1:0][OPW-1:0] ops,
  input  logic [NOPS-1:0]          subs,
  output logic [NCH-1:0][RESW-1:0] resOut,
  output logic [VALW-1:0]          valOut
);
  logic [NCH-1:0][RESW-1:0] resNext;
  logic [NCH-1:0][RESW-1:0] resStage;
  logic [VALW-1:0]          crtVal;
  int                       crtSum;

  genvar ch;
  generate
    for (ch = 0; ch < NCH; ch++) begin : gChan
      rnsChannel #(.MOD(MODS[ch]), .OPW(OPW), .NOPS(NOPS), .RESW(RESW)) chanInst (
        .ops(ops), .subs(subs), .residue(resNext[ch])
      );
    end
  endgenerate

  always_comb begin
    crtSum = 0;
    for (int i = 0; i < NCH; i++) crtSum = crtSum + int'(resStage[i]) * crtWeight(i);
    crtVal = VALW'(crtSum % MTOT);
  end

  always_ff @(posedge clk) begin
    if (strobes.load1) resStage <= resNext;
    if (strobes.load2) begin
      resOut <= resStage;
      valOut <= crtVal;
    end
  end
endmodule

// File: rtl/rnsAdder.sv
module rnsAdder
  import rnsPkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  output logic            inReady,
  input  logic [OPW-1:0]  opA,
  input  logic [OPW-1:0]  opB,
  input  logic [OPW-1:0]  opC,
  input  logic            subA,
  input  logic            subB,
  input  logic            subC,
  output logic            outValid,
  input  logic            outReady,
  output logic [RESW-1:0] resCh0,
  output logic [RESW-1:0] resCh1,
  output logic [RESW-1:0] resCh2,
  output logic [VALW-1:0] outValue
);
  ctrlStrobes_t             strobes;
  logic [NCH-1:0][RESW-1:0] resOut;

  rnsCtrl ctrlInst (
    .clk(clk), .rstN(rstN), .inValid(inValid), .outReady(outReady),
    .inReady(inReady), .outValid(outValid), .strobes(strobes)
  );

  rnsDatapath dpInst (
    .clk(clk), .strobes(strobes),
    .ops({opC, opB, opA}), .subs({subC, subB, subA}),
    .resOut(resOut), .valOut(outValue)
  );

  assign resCh0 = resOut[0];
  assign resCh1 = resOut[1];
  assign resCh2 = resOut[2];
endmodule

// File: rtl/rnsAdderChk.sv
module rnsAdderChk
  import rnsPkg::*;
(
  input logic            clk,
  input logic            rstN,
  input logic            inValid,
  input logic            inReady,
  input logic            outValid,
  input logic            outReady,
  input logic [RESW-1:0] resCh0,
  input logic [RESW-1:0] resCh1,
  input logic [RESW-1:0] resCh2,
  input logic [VALW-1:0] outValue
);
  // R4
  value_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> int'(outValue) < MTOT);

  // R4
  residue_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ((int'(outValue) % MODS[0]) == int'(resCh0)) &&
                 ((int'(outValue) % MODS[1]) == int'(resCh1)) &&
                 ((int'(outValue) % MODS[2]) == int'(resCh2)));

  // R5
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> $past(inValid && inReady, 2));

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid && $stable(outValue) &&
      $stable(resCh0) && $stable(resCh1) && $stable(resCh2));

  // R7
  ready_when_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> inReady);
endmodule

bind rnsAdder rnsAdderChk chk (.*);

// File: tb/tb_rnsAdder.sv
module tb_rnsAdder;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic outReady = 1'b0;
  logic [9:0] opA = '0, opB = '0, opC = '0;
  logic subA = 1'b0, subB = 1'b0, subC = 1'b0;
  logic inReady, outValid;
  logic [3:0] resCh0, resCh1, resCh2;
  logic [9:0] outValue;
  logic [3:0] r12;

  int checks = 0;
  int failures = 0;
  int expQ[$];
  int expTag[$];
  logic prevStall = 1'b0;
  logic [9:0] savedVal;
  logic [3:0] saved0, saved1, saved2;

  always #10 clk = ~clk;

  rnsAdder dut (.*);

  // R9: channel built with modulus 12
  rnsChannel #(.MOD(12), .OPW(4), .NOPS(3)) chan12 (
    .ops({4'd3, 4'd7, 4'd10}), .subs(3'b100), .residue(r12)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expVal(int a, int b, int c, logic [2:0] s);
    int t = (s[0] ? -a : a) + (s[1] ? -b : b) + (s[2] ? -c : c);
    t = t % 630;
    if (t < 0) t += 630;
    return t;
  endfunction

  // one cycle: drive at negedge, observe handshakes that happen at the next posedge
  task automatic step(input logic v, input int a, input int b, input int c,
                      input logic [2:0] s, input logic rdy);
    int e, tag;
    inValid = v; opA = 10'(a); opB = 10'(b); opC = 10'(c);
    {subC, subB, subA} = s; outReady = rdy;
    #1;
    if (prevStall) begin
      check(outValid && outValue == savedVal && resCh0 == saved0 &&
            resCh1 == saved1 && resCh2 == saved2, "R6 hold", int'(outValue), int'(savedVal));
    end
    if (inValid && inReady) begin
      expQ.push_back(expVal(a, b, c, s));
      expTag.push_back(s == 3'b000 ? 1 : 2);
    end
    if (outValid && outReady) begin
      if (expQ.size() == 0) check(1'b0, "R6 spurious", int'(outValue), -1);
      else begin
        e = expQ.pop_front();
        tag = expTag.pop_front();
        check(outValue == 10'(e), "R3 value", int'(outValue), e);
        check(int'(resCh0) == e % 10, tag == 1 ? "R1 mod10" : "R2 mod10", int'(resCh0), e % 10);
        check(int'(resCh1) == e % 9,  tag == 1 ? "R1 mod9"  : "R2 mod9",  int'(resCh1), e % 9);
        check(int'(resCh2) == e % 7,  tag == 1 ? "R1 mod7"  : "R2 mod7",  int'(resCh2), e % 7);
      end
    end
    prevStall = outValid && !outReady;
    savedVal = outValue; saved0 = resCh0; saved1 = resCh1; saved2 = resCh2;
    @(negedge clk);
  endtask

  task automatic drain();
    for (int i = 0; i < 6; i++) step(1'b0, 0, 0, 0, 3'b000, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8
    check(outValid == 1'b0, "R8 outValid", int'(outValid), 0);
    check(inReady == 1'b1, "R8 inReady", int'(inReady), 1);
    rstN = 1'b1;
    @(negedge clk);

    // R9
    check(int'(r12) == 2, "R9 mod12", int'(r12), 2);

    // R5: latency from an empty pipeline
    step(1'b1, 10, 20, 30, 3'b000, 1'b1);
    check(outValid == 1'b0, "R5 after first edge", int'(outValid), 0);
    step(1'b0, 0, 0, 0, 3'b000, 1'b1);
    check(outValid == 1'b1, "R5 after second edge", int'(outValid), 1);
    drain();

    // R3 corner cases: wrap above and below the range
    step(1'b1, 500, 300, 35, 3'b000, 1'b1);
    step(1'b1, 0, 5, 0, 3'b010, 1'b1);
    step(1'b1, 1023, 1023, 1023, 3'b000, 1'b1);
    step(1'b1, 1023, 1023, 1023, 3'b111, 1'b1);
    step(1'b1, 630, 0, 0, 3'b000, 1'b1);
    drain();

    // R6: fill both stages under stall, then release
    step(1'b1, 1, 2, 3, 3'b000, 1'b0);
    step(1'b1, 4, 5, 6, 3'b001, 1'b0);
    step(1'b1, 7, 8, 9, 3'b100, 1'b0);
    check(inReady == 1'b0, "R6 full", int'(inReady), 0);
    check(outValid == 1'b1, "R6 full valid", int'(outValid), 1);
    step(1'b1, 7, 8, 9, 3'b100, 1'b0);
    drain();

    // R7: empty output stage keeps input open
    check(inReady == 1'b1, "R7 empty", int'(inReady), 1);

    // sweep: every opA, every flag pattern, periodic stalls
    for (int a = 0; a < 1024; a++) begin
      for (int s = 0; s < 8; s++) begin
        step(1'b1, a, (a * 37 + 11) % 1024, (a * 101 + 5) % 1024, 3'(s), ((a + s) % 5) != 0);
      end
    end
    drain();
    drain();
    check(expQ.size() == 0, "R6 no loss", expQ.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule